// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block keeps the operating mode of a synchronous DRAM and, once a read or write burst starts, produces one column address per clock together with a flag that marks the final beat. A controller writes a 12-bit mode word. The block checks that word and keeps it only when every field is legal. The controller then pulses a start with a column and a read/write qualifier, and takes the column stream and the last-beat flag to drive its data path.

A burst visits an aligned group of columns whose size is the burst length. The visiting order is either a linear count that wraps inside the group or an XOR interleave. A full-page burst walks the whole row and keeps going until it is stopped. One mode bit shortens writes to a single beat while reads keep the programmed length. A stop pulse ends a burst early. A new start replaces the running burst at once. The mode is sampled when a burst starts, so a mode write made during a burst affects only later bursts.

Top module: `sdram_burst_sequencer`

## Requirements
- R1: After reset no beat is presented, `cas_lat_o` is 2, and the mode is burst length 1, sequential order, with writes using the programmed length.
- R2: The mode word uses these fields. Bits [2:0] select the length: 000=1, 001=2, 010=4, 011=8, 111=full page. Bit 3 selects the order: 0=sequential, 1=interleaved. Bits [6:4] hold the CAS latency and must be 010 or 011. Bit 9 set makes writes single-beat. Bits [8:7] and [11:10] must be 0. A legal word is taken at the write edge, and `cas_lat_o` shows bits [5:4] from the next cycle on.
- R3: A mode write with any illegal field is ignored, and the whole previous mode is kept.
- R4: A start sampled at an edge puts beat 0 on the outputs right after that edge. Each later edge moves to the next beat.
- R5: In sequential order, for length BL, beat k has its low log2(BL) column bits equal to (start + k) mod BL. The upper bits equal those of the start column.
- R6: In interleaved order, beat k has its low log2(BL) bits equal to the start bits XOR k. The upper bits are unchanged.
- R7: For lengths 1, 2, 4 and 8, `last_o` is high on beat BL-1 only. With no new start, `beat_valid_o` is low after that beat.
- R8: A full-page burst outputs (start + k) mod 512 whatever the order bit is. It never raises `last_o` and runs until it is stopped or restarted.
- R9: A stop sampled during a burst ends it: no beat follows that edge. A start in the same cycle takes priority over the stop.
- R10: A start during a running burst begins a new burst at beat 0 of the new column.
- R11: With bit 9 set, a write start gives exactly one beat, with `last_o` high. A read start uses the programmed length.
- R12: A burst uses the mode in force at its start edge. A mode write in the same cycle or during the burst does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode word write strobe |
| mode_val_i | input | 12 | Mode word |
| start_i | input | 1 | Burst start pulse |
| start_wr_i | input | 1 | Start is a write (1) or a read (0) |
| start_col_i | input | 9 | Starting column |
| stop_i | input | 1 | Burst stop |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| col_o | output | 9 | Column of the current beat |
| last_o | output | 1 | Current beat is the final one |
| cas_lat_o | output | 2 | Programmed CAS latency |

## Verification
The hardest case to reach from the ports is an overlap of events: a mode write, a restart or a stop arriving while a burst is partway through, especially a wrapping full-page burst or a single-beat write. Directed sequences cover each of these overlaps at known beats. A long random run then mixes legal mode words, arbitrary 12-bit words, starts, stops and read/write selection, with a low stop rate so full-page bursts also cross the row end. A bench model built from the requirements predicts every output on every cycle.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int unsigned MODE_W = 12;
  localparam int unsigned COL_W  = 9;

  // Mode word field positions
  localparam int unsigned BL_LSB  = 0;
  localparam int unsigned ORD_BIT = 3;
  localparam int unsigned CL_LSB  = 4;
  localparam int unsigned TM_LSB  = 7;
  localparam int unsigned WS_BIT  = 9;
  localparam int unsigned RSV_LSB = 10;

  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;

  typedef struct packed {
    bl_code_e   bl;
    logic       ilv;
    logic [1:0] cas_lat;
    logic       wr_single;
  } mode_t;

  localparam mode_t MODE_RESET = '{bl: BL_1, ilv: 1'b0, cas_lat: 2'd2, wr_single: 1'b0};
endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_burst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MODE_W-1:0] val_i,
  output mode_t             mode_o
);
  mode_t mode_q, mode_d;
  logic  bl_ok, cl_ok, tm_ok, rsv_ok, word_ok;

  always_comb begin
    unique case (val_i[BL_LSB +: 3])
      3'b000, 3'b001, 3'b010, 3'b011, 3'b111: bl_ok = 1'b1;
      default:                                bl_ok = 1'b0;
    endcase
    cl_ok   = (val_i[CL_LSB +: 3] == 3'd2) || (val_i[CL_LSB +: 3] == 3'd3);
    tm_ok   = (val_i[TM_LSB +: 2] == 2'b00);
    rsv_ok  = (val_i[RSV_LSB +: 2] == 2'b00);
    word_ok = bl_ok && cl_ok && tm_ok && rsv_ok;

    mode_d.bl        = bl_code_e'(val_i[BL_LSB +: 3]);
    mode_d.ilv       = val_i[ORD_BIT];
    mode_d.cas_lat   = val_i[CL_LSB +: 2];
    mode_d.wr_single = val_i[WS_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              mode_q <= MODE_RESET;
    else if (wr_i && word_ok) mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  a_r3_reject_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !word_ok) |=> $stable(mode_q));
  a_r2_cas_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.cas_lat == 2'd2) || (mode_q.cas_lat == 2'd3));
  a_r2_accept_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word_ok) |=> (mode_q.cas_lat == $past(val_i[CL_LSB +: 2])));
endmodule

// File: rtl/sdram_beat_ctrl.sv
module sdram_beat_ctrl
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COLW = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            is_wr_i,
  input  logic [COLW-1:0] col_i,
  input  logic            stop_i,
  input  bl_code_e        bl_i,
  input  logic            ilv_i,
  input  logic            wr_single_i,
  output logic            active_o,
  output logic [COLW-1:0] base_o,
  output logic [COLW-1:0] idx_o,
  output logic [COLW-1:0] mask_o,
  output logic            ilv_o,
  output logic            full_o,
  output logic            last_o
);
  logic            active_q, ilv_q, full_q, one_beat;
  logic [COLW-1:0] base_q, idx_q, mask_q, mask_d;

  always_comb begin
    unique case (bl_i)
      BL_1:    mask_d = COLW'(0);
      BL_2:    mask_d = COLW'(1);
      BL_4:    mask_d = COLW'(3);
      BL_8:    mask_d = COLW'(7);
      default: mask_d = '1;
    endcase
    one_beat = is_wr_i && wr_single_i;
  end

  assign last_o = active_q && !full_q && (idx_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      ilv_q    <= 1'b0;
      full_q   <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      base_q   <= col_i;
      mask_q   <= one_beat ? COLW'(0) : mask_d;
      ilv_q    <= ilv_i;
      full_q   <= (bl_i == BL_PAGE) && !one_beat;
    end else if (active_q) begin
      if (stop_i || last_o) active_q <= 1'b0;
      else                  idx_q    <= idx_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign base_o   = base_q;
  assign idx_o    = idx_q;
  assign mask_o   = mask_q;
  assign ilv_o    = ilv_q;
  assign full_o   = full_q;

  a_r4_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (active_q && idx_q == '0));
  a_r9_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && stop_i && !start_i) |=> !active_q);
  a_r7_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !active_q);
  a_r10_restart_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && start_i) |=> (base_q == $past(col_i)));
  a_r8_full_no_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> !last_o);
  a_r11_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && is_wr_i && wr_single_i) |=> last_o);
endmodule

// File: rtl/sdram_col_order.sv
module sdram_col_order #(
  parameter int unsigned COLW = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic [COLW-1:0] base_i,
  input  logic [COLW-1:0] idx_i,
  input  logic [COLW-1:0] mask_i,
  input  logic            ilv_i,
  input  logic            full_i,
  output logic [COLW-1:0] col_o
);
  logic [COLW-1:0] sum;
  logic            use_xor;

  assign sum     = base_i + idx_i;
  assign use_xor = ilv_i && !full_i;  // full page is always linear

  for (genvar b = 0; b < COLW; b++) begin : g_bit
    assign col_o[b] = !mask_i[b] ? base_i[b]
                    : (use_xor ? (base_i[b] ^ idx_i[b]) : sum[b]);
  end

  a_r5_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (((col_o ^ base_i) & ~mask_i) == '0));
endmodule

// File: rtl/sdram_burst_sequencer.sv
module sdram_burst_sequencer
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COLW = sdram_burst_pkg::COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_val_i,
  input  logic              start_i,
  input  logic              start_wr_i,
  input  logic [COLW-1:0]   start_col_i,
  input  logic              stop_i,
  output logic              beat_valid_o,
  output logic [COLW-1:0]   col_o,
  output logic              last_o,
  output logic [1:0]        cas_lat_o
);
  mode_t           mode;
  logic            active, ilv, full;
  logic [COLW-1:0] base, idx, mask;

  sdram_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (mode_we_i),
    .val_i  (mode_val_i),
    .mode_o (mode)
  );

  sdram_beat_ctrl #(.COLW(COLW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .is_wr_i     (start_wr_i),
    .col_i       (start_col_i),
    .stop_i      (stop_i),
    .bl_i        (mode.bl),
    .ilv_i       (mode.ilv),
    .wr_single_i (mode.wr_single),
    .active_o    (active),
    .base_o      (base),
    .idx_o       (idx),
    .mask_o      (mask),
    .ilv_o       (ilv),
    .full_o      (full),
    .last_o      (last_o)
  );

  sdram_col_order #(.COLW(COLW)) u_order (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .base_i   (base),
    .idx_i    (idx),
    .mask_i   (mask),
    .ilv_i    (ilv),
    .full_i   (full),
    .col_o    (col_o)
  );

  assign beat_valid_o = active;
  assign cas_lat_o    = mode.cas_lat;

  a_r7_last_needs_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> beat_valid_o);
endmodule

// File: tb/sdram_burst_sequencer_tb_top.sv
module sdram_burst_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, st = 1'b0, wr = 1'b0, sp = 1'b0;
  logic [11:0] val = '0;
  logic [8:0]  col = '0;
  logic        bv, lst;
  logic [8:0]  co;
  logic [1:0]  cl;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  int m_code = 0, m_ilv = 0, m_cl = 2, m_ws = 0;
  int b_act = 0, b_base = 0, b_idx = 0, b_len = 1, b_ilv = 0, b_full = 0;

  always #10 clk = ~clk;

  sdram_burst_sequencer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(we), .mode_val_i(val),
    .start_i(st), .start_wr_i(wr), .start_col_i(col), .stop_i(sp),
    .beat_valid_o(bv), .col_o(co), .last_o(lst), .cas_lat_o(cl));

  function automatic bit word_ok(logic [11:0] v);
    bit c = (v[2:0] inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111});
    return c && (v[6:4] == 3'd2 || v[6:4] == 3'd3) && v[8:7] == 2'b00 && v[11:10] == 2'b00;
  endfunction

  function automatic int len_of(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 512;
    endcase
  endfunction

  function automatic logic [11:0] mk(int code, int ilv, int lat, int ws);
    return {2'b00, ws[0], 2'b00, lat[2:0], ilv[0], code[2:0]};
  endfunction

  function automatic int exp_col();
    int m, low;
    if (b_full != 0) return (b_base + b_idx) % 512;
    m   = b_len - 1;
    low = (b_ilv != 0) ? ((b_base ^ b_idx) & m) : ((b_base + b_idx) & m);
    return (b_base & ~m & 511) | low;
  endfunction

  function automatic int exp_last();
    return (b_act != 0 && b_full == 0 && b_idx == b_len - 1) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit i_we, logic [11:0] i_val, bit i_st, bit i_wr, int i_col, bit i_sp);
    chk("R4 beat_valid", int'(bv), b_act);
    if (b_act != 0)
      chk(b_full != 0 ? "R8 col" : (b_ilv != 0 ? "R6 col" : "R5 col"), int'(co), exp_col());
    chk("R7 last", int'(lst), exp_last());
    chk("R2 cas_lat", int'(cl), m_cl);
    we = i_we; val = i_val; st = i_st; wr = i_wr; col = i_col[8:0]; sp = i_sp;
    @(posedge clk);
    if (i_st) begin
      int one = (i_wr && m_ws != 0) ? 1 : 0;
      b_act = 1; b_idx = 0; b_base = i_col % 512; b_ilv = m_ilv;
      b_len = one != 0 ? 1 : len_of(m_code);
      b_full = (m_code == 7 && one == 0) ? 1 : 0;
    end else if (b_act != 0) begin
      if (i_sp || exp_last() != 0) b_act = 0;
      else b_idx = (b_idx + 1) % 512;
    end
    if (i_we && word_ok(i_val)) begin
      m_code = int'(i_val[2:0]); m_ilv = int'(i_val[3]);
      m_cl = int'(i_val[5:4]); m_ws = int'(i_val[9]);
    end
    @(negedge clk);
    we = 1'b0; st = 1'b0; sp = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 no beat", int'(bv), 0);
    chk("R1 cas_lat", int'(cl), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no beat after release", int'(bv), 0);
    step(0, '0, 1, 0, 37, 0);
    chk("R1 default single beat last", int'(lst), 1);
    idle(2);

    // R2 sequential BL4, CL3
    step(1, mk(2, 0, 3, 0), 0, 0, 0, 0);
    chk("R2 cas_lat now 3", int'(cl), 3);
    step(0, '0, 1, 0, 270, 0);
    chk("R5 beat0 col", int'(co), 270);
    step(0, '0, 0, 0, 0, 0);
    chk("R5 beat1 col", int'(co), 271);
    step(0, '0, 0, 0, 0, 0);
    chk("R5 wrap col", int'(co), 268);
    idle(3);

    // R6 interleaved BL8
    step(1, mk(3, 1, 2, 0), 0, 0, 0, 0);
    step(0, '0, 1, 1, 45, 0);
    chk("R6 beat0 col", int'(co), 45);
    step(0, '0, 0, 0, 0, 0);
    chk("R6 beat1 col", int'(co), 44);
    idle(8);

    // R3 illegal words
    step(1, 12'h180 | mk(1, 0, 3, 0), 0, 0, 0, 0);
    chk("R3 test bits kept mode", int'(cl), 2);
    step(1, mk(5, 0, 3, 0), 0, 0, 0, 0);
    step(1, mk(1, 0, 4, 0), 0, 0, 0, 0);
    step(1, 12'h400 | mk(0, 0, 3, 0), 0, 0, 0, 0);
    chk("R3 cas_lat unchanged", int'(cl), 2);
    step(0, '0, 1, 0, 8, 0);
    idle(7);
    chk("R3 still BL8 last", int'(lst), 1);
    idle(2);

    // R8 full page wraps past 511, R9 stop
    step(1, mk(7, 1, 3, 0), 0, 0, 0, 0);
    step(0, '0, 1, 0, 509, 0);
    idle(4);
    chk("R8 wrapped col", int'(co), 1);
    idle(20);
    step(0, '0, 0, 0, 0, 1);
    chk("R9 stopped", int'(bv), 0);
    // R9 start beats stop
    step(0, '0, 1, 0, 100, 0);
    step(0, '0, 1, 0, 200, 1);
    chk("R9 start wins", int'(co), 200);
    // R10 restart
    idle(3);
    step(0, '0, 1, 0, 300, 0);
    chk("R10 restart col", int'(co), 300);
    step(0, '0, 0, 0, 0, 1);

    // R11 single write
    step(1, mk(3, 0, 2, 1), 0, 0, 0, 0);
    step(0, '0, 1, 1, 66, 0);
    chk("R11 write one beat", int'(lst), 1);
    step(0, '0, 0, 0, 0, 0);
    chk("R11 ended", int'(bv), 0);
    step(0, '0, 1, 0, 66, 0);
    chk("R11 read not last", int'(lst), 0);
    idle(8);

    // R12 mode change mid-burst and at start edge
    step(1, mk(3, 0, 2, 0), 0, 0, 0, 0);
    step(1, mk(0, 0, 2, 0), 1, 0, 16, 0);
    step(0, '0, 0, 0, 0, 0);
    chk("R12 same-edge write ignored", int'(bv), 1);
    step(1, mk(1, 1, 3, 0), 0, 0, 0, 0);
    idle(3);
    chk("R12 burst keeps length", int'(bv), 1);
    idle(5);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      bit r_we, r_st, r_wr, r_sp;
      logic [11:0] r_val;
      int codes[5] = '{0, 1, 2, 3, 7};
      r_we = ($urandom % 100) < 6;
      if ($urandom % 2)
        r_val = mk(codes[$urandom % 5], $urandom % 2, 2 + $urandom % 2, $urandom % 2);
      else
        r_val = 12'($urandom);
      r_st = ($urandom % 100) < 12;
      r_wr = $urandom % 2;
      r_sp = ($urandom % 100) < 3;
      step(r_we, r_val, r_st, r_wr, $urandom % 512, r_sp);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule